// File: doc/BRIEF.md
# Function Readiness Message Queue

This block lives in a root port or an event collector. It accepts readiness notifications that have already been decoded from the link and keeps them for software. A notification carries no payload. Its meaning comes from a two-bit type code, the requester ID of the sender and a reason code. Two kinds of notification are recognised. A function-ready notification is written into a first-in first-out queue as a pair of requester ID and reason. A device-ready notification does not enter the queue directly. It updates two status flags: one records that the message arrived, the other records that a component is present below the port.

Software can poll the head of the queue and its fill count. It can also enable an interrupt that stays asserted while entries are waiting. A pop strobe removes the head entry. The status flags are cleared by writing 1 to them. A per-port signalling control decides what a device-ready message does beyond setting the flags. It can raise the interrupt, or it can put an entry into the queue that stands for the port itself. The queue depth is a parameter with a legal range of 1 to 4095.

Top module: `rdy_notif_queue`

## Requirements
- R1: After reset the queue is empty (`q_count` 0, `head_valid` 0, head fields 0), all three status flags are 0 and `irq` is 0.
- R2: A cycle with `msg_valid`=1 and `msg_type`=2'b10 (function ready) appends {`msg_rid`, `msg_reason`}. Entries leave in arrival order. A new head appears on the outputs one cycle after the message.
- R3: A function-ready message that arrives while the queue holds `DEPTH` entries, with no pop accepted in the same cycle, is dropped. The queue contents stay unchanged and `st_overflow` is set and stays set.
- R4: `pop` removes the head entry in the next cycle. A `pop` on an empty queue has no effect.
- R5: Type codes 2'b00 and 2'b11 are ignored. They change neither the queue nor any status flag.
- R6: A cycle with `msg_valid`=1 and `msg_type`=2'b01 (device ready) sets `st_received` and `st_present` in the next cycle.
- R7: Writing 1 to `clr_w1c` bit 0 clears `st_received`, bit 1 clears `st_overflow` and bit 2 clears `st_present`. If a set event for the same flag occurs in the same cycle, the set wins.
- R8: `irq` = `irq_en` AND (queue non-empty OR (`st_received` AND `drs_sig_en` AND NOT `drs_sig_sel`)).
- R9: If `drs_sig_en`=1 and `drs_sig_sel`=1, a device-ready message also appends the entry {`own_rid`, `DEV_REASON`} (default 4'hF). This entry follows the same full and drop rules as R3.
- R10: If a push and an accepted pop fall in the same cycle while the queue is full, both take effect. The count stays at `DEPTH` and no overflow is flagged. If the queue is empty, the pop is ignored and the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Decoded notification strobe |
| msg_type | input | 2 | 01 device ready, 10 function ready, others ignored |
| msg_rid | input | ID_W | Requester ID of the notification |
| msg_reason | input | RSN_W | Reason code of the notification |
| pop | input | 1 | Remove the head entry |
| clr_w1c | input | 3 | Write-1-to-clear for received, overflow and present flags |
| irq_en | input | 1 | Interrupt enable |
| drs_sig_en | input | 1 | Enable signalling on device-ready receipt |
| drs_sig_sel | input | 1 | 0 signals by interrupt, 1 signals by a queue entry |
| own_rid | input | ID_W | Requester ID of this port, used for self entries |
| head_valid | output | 1 | Queue holds at least one entry |
| head_rid | output | ID_W | Requester ID of the head entry (0 when empty) |
| head_reason | output | RSN_W | Reason of the head entry (0 when empty) |
| q_count | output | CNT_W | Number of stored entries |
| st_received | output | 1 | Device-ready message received |
| st_present | output | 1 | Downstream component present |
| st_overflow | output | 1 | Sticky flag for a dropped entry |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a push and a pop on a full queue. The second pair is a write-1-to-clear and a new set event for the same flag. The bench sets up both cases with directed stimulus. With a four-entry queue, it fills the queue and then issues a message together with a pop. It also issues a device-ready message together with a clear of bit 0, and a drop together with a clear of bit 1. The random phase hits both cases many more times. In every case a bench model judges the outcome: a full-queue push with an accepted pop must keep the count and leave the overflow flag alone, and a set must win over a clear.

// File: rtl/rdyq_pkg.sv
package rdyq_pkg;
  typedef enum logic [1:0] {
    MT_RSV0 = 2'b00,
    MT_DEV  = 2'b01,
    MT_FN   = 2'b10,
    MT_RSV3 = 2'b11
  } msg_kind_e;

  localparam int CLR_RECEIVED = 0;
  localparam int CLR_OVERFLOW = 1;
  localparam int CLR_PRESENT  = 2;

  function automatic logic kind_is_known(input logic [1:0] t);
    return (t == MT_DEV) || (t == MT_FN);
  endfunction
endpackage

// File: rtl/rdyq_classify.sv
module rdyq_classify
  import rdyq_pkg::*;
#(
  parameter int ID_W = 16,
  parameter int RSN_W = 4,
  parameter logic [RSN_W-1:0] DEV_REASON = '1
) (
  input  logic                   msg_valid,
  input  logic [1:0]             msg_type,
  input  logic [ID_W-1:0]        msg_rid,
  input  logic [RSN_W-1:0]       msg_reason,
  input  logic [ID_W-1:0]        own_rid,
  input  logic                   sig_en,
  input  logic                   sig_sel,
  output logic                   fn_push,
  output logic                   dev_evt,
  output logic [ID_W+RSN_W-1:0]  push_data
);
  logic known;
  logic is_fn;

  assign known   = msg_valid & kind_is_known(msg_type);
  assign is_fn   = known & (msg_type == MT_FN);
  assign dev_evt = known & (msg_type == MT_DEV);
  assign fn_push = is_fn | (dev_evt & sig_en & sig_sel);

  always_comb begin
    if (is_fn) push_data = {msg_rid, msg_reason};
    else       push_data = {own_rid, DEV_REASON};
  end
endmodule

// File: rtl/rdyq_fifo.sv
module rdyq_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 20,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             push_acc,
  output logic             pop_acc,
  output logic             push_drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign pop_acc   = pop_req & ~empty;
  assign push_acc  = push_req & (~full | pop_acc);
  assign push_drop = push_req & ~push_acc;
  assign head_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_acc, pop_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rdyq_status.sv
module rdyq_status
  import rdyq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_evt,
  input  logic       drop_evt,
  input  logic [2:0] clr_w1c,
  output logic       received,
  output logic       present,
  output logic       overflow
);
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      received <= 1'b0;
      present  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      received <= flag_next(received, dev_evt,  clr_w1c[CLR_RECEIVED]);
      present  <= flag_next(present,  dev_evt,  clr_w1c[CLR_PRESENT]);
      overflow <= flag_next(overflow, drop_evt, clr_w1c[CLR_OVERFLOW]);
    end
  end
endmodule

// File: rtl/rdy_notif_queue.sv
module rdy_notif_queue #(
  parameter int DEPTH = 16,
  parameter int ID_W = 16,
  parameter int RSN_W = 4,
  parameter logic [RSN_W-1:0] DEV_REASON = '1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_type,
  input  logic [ID_W-1:0]  msg_rid,
  input  logic [RSN_W-1:0] msg_reason,
  input  logic             pop,
  input  logic [2:0]       clr_w1c,
  input  logic             irq_en,
  input  logic             drs_sig_en,
  input  logic             drs_sig_sel,
  input  logic [ID_W-1:0]  own_rid,
  output logic             head_valid,
  output logic [ID_W-1:0]  head_rid,
  output logic [RSN_W-1:0] head_reason,
  output logic [CNT_W-1:0] q_count,
  output logic             st_received,
  output logic             st_present,
  output logic             st_overflow,
  output logic             irq
);
  localparam int ENT_W = ID_W + RSN_W;

  logic             fn_push;
  logic             dev_evt;
  logic [ENT_W-1:0] push_data;
  logic [ENT_W-1:0] head_data;
  logic             fifo_empty, fifo_full;
  logic             push_acc, pop_acc, push_drop;

  rdyq_classify #(.ID_W(ID_W), .RSN_W(RSN_W), .DEV_REASON(DEV_REASON)) cls_i (
    .msg_valid (msg_valid),
    .msg_type  (msg_type),
    .msg_rid   (msg_rid),
    .msg_reason(msg_reason),
    .own_rid   (own_rid),
    .sig_en    (drs_sig_en),
    .sig_sel   (drs_sig_sel),
    .fn_push   (fn_push),
    .dev_evt   (dev_evt),
    .push_data (push_data)
  );

  rdyq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (fn_push),
    .push_data (push_data),
    .pop_req   (pop),
    .head_data (head_data),
    .count     (q_count),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .push_drop (push_drop)
  );

  rdyq_status stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_evt (dev_evt),
    .drop_evt(push_drop),
    .clr_w1c (clr_w1c),
    .received(st_received),
    .present (st_present),
    .overflow(st_overflow)
  );

  assign head_valid  = ~fifo_empty;
  assign head_rid    = head_data[ENT_W-1:RSN_W];
  assign head_reason = head_data[RSN_W-1:0];
  assign irq = irq_en & (~fifo_empty | (st_received & drs_sig_en & ~drs_sig_sel));
endmodule

// File: rtl/rdyq_checker.sv
module rdyq_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [1:0]       msg_type,
  input logic             pop,
  input logic             irq,
  input logic             irq_en,
  input logic [CNT_W-1:0] q_count,
  input logic             st_received,
  input logic             st_present,
  input logic             st_overflow,
  input logic             fn_push,
  input logic             dev_evt,
  input logic             push_acc,
  input logic             pop_acc,
  input logic             push_drop,
  input logic             fifo_full
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> st_overflow);
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !pop_acc) |=> q_count == $past(q_count) + 1'b1);
  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !push_acc) |=> q_count == $past(q_count) - 1'b1);
  assert_empty_pop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_count == '0 && !fn_push) |=> q_count == '0);
  assert_rsv_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_type == 2'b00 || msg_type == 2'b11)) |-> (!fn_push && !dev_evt));
  assert_dev_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_evt |=> (st_received && st_present));
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && fn_push && pop) |=> (q_count == $past(q_count)));
endmodule

bind rdy_notif_queue rdyq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_type   (msg_type),
  .pop        (pop),
  .irq        (irq),
  .irq_en     (irq_en),
  .q_count    (q_count),
  .st_received(st_received),
  .st_present (st_present),
  .st_overflow(st_overflow),
  .fn_push    (fn_push),
  .dev_evt    (dev_evt),
  .push_acc   (push_acc),
  .pop_acc    (pop_acc),
  .push_drop  (push_drop),
  .fifo_full  (fifo_full)
);

// File: tb/rdy_notif_queue_tb_top.sv
module rdy_notif_queue_tb_top;
  localparam int D = 4;
  localparam int CW = $clog2(D + 1);
  localparam logic [3:0] DEVR = 4'hF;
  localparam logic [15:0] OWN = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [1:0] msg_type = 2'b00;
  logic [15:0] msg_rid = '0;
  logic [3:0] msg_reason = '0;
  logic pop = 1'b0;
  logic [2:0] clr_w1c = '0;
  logic irq_en = 1'b0, drs_sig_en = 1'b0, drs_sig_sel = 1'b0;
  logic head_valid, st_received, st_present, st_overflow, irq;
  logic [15:0] head_rid;
  logic [3:0] head_reason;
  logic [CW-1:0] q_count;

  always #2.5 clk = ~clk;

  rdy_notif_queue #(.DEPTH(D), .ID_W(16), .RSN_W(4), .DEV_REASON(DEVR)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_type(msg_type),
    .msg_rid(msg_rid), .msg_reason(msg_reason), .pop(pop), .clr_w1c(clr_w1c),
    .irq_en(irq_en), .drs_sig_en(drs_sig_en), .drs_sig_sel(drs_sig_sel), .own_rid(OWN),
    .head_valid(head_valid), .head_rid(head_rid), .head_reason(head_reason),
    .q_count(q_count), .st_received(st_received), .st_present(st_present),
    .st_overflow(st_overflow), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_rid [D];
  logic [3:0]  m_rsn [D];
  int m_cnt = 0;
  bit m_rec = 0, m_pres = 0, m_ovf = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    return irq_en && (m_cnt > 0 || (m_rec && drs_sig_en && !drs_sig_sel));
  endfunction

  task automatic compare(input string tag);
    chk(q_count == CW'(m_cnt), tag, "count", int'(q_count), m_cnt);
    chk(head_valid == (m_cnt > 0), tag, "head_valid", int'(head_valid), int'(m_cnt > 0));
    chk(head_rid == (m_cnt > 0 ? m_rid[0] : 16'h0), tag, "head_rid", int'(head_rid),
        int'(m_cnt > 0 ? m_rid[0] : 16'h0));
    chk(head_reason == (m_cnt > 0 ? m_rsn[0] : 4'h0), tag, "head_reason", int'(head_reason),
        int'(m_cnt > 0 ? m_rsn[0] : 4'h0));
    chk({st_received, st_present, st_overflow} == {m_rec, m_pres, m_ovf}, tag, "status",
        int'({st_received, st_present, st_overflow}), int'({m_rec, m_pres, m_ovf}));
    chk(irq == exp_irq(), tag, "irq", int'(irq), int'(exp_irq()));
  endtask

  // Bench model of one clock edge, built from R2..R10.
  task automatic model(input bit v, input logic [1:0] t, input logic [15:0] r,
                       input logic [3:0] rs, input bit p, input logic [2:0] c);
    bit dev = v && t == 2'b01;
    bit preq = (v && t == 2'b10) || (dev && drs_sig_en && drs_sig_sel);
    logic [15:0] pr = (v && t == 2'b10) ? r : OWN;
    logic [3:0] ps = (v && t == 2'b10) ? rs : DEVR;
    bit pok = p && m_cnt > 0;
    bit sok = preq && (m_cnt < D || pok);
    m_rec  = dev | (m_rec & ~c[0]);
    m_pres = dev | (m_pres & ~c[2]);
    m_ovf  = (preq && !sok) | (m_ovf & ~c[1]);
    if (pok) begin
      for (int i = 0; i < D - 1; i++) begin m_rid[i] = m_rid[i+1]; m_rsn[i] = m_rsn[i+1]; end
      m_cnt--;
    end
    if (sok) begin m_rid[m_cnt] = pr; m_rsn[m_cnt] = ps; m_cnt++; end
  endtask

  task automatic cyc(input bit v, input logic [1:0] t, input logic [15:0] r,
                     input logic [3:0] rs, input bit p, input logic [2:0] c, input string tag);
    @(negedge clk);
    msg_valid = v; msg_type = t; msg_rid = r; msg_reason = rs; pop = p; clr_w1c = c;
    model(v, t, r, rs, p, c);
    @(posedge clk); #1;
    compare(tag);
    msg_valid = 0; pop = 0; clr_w1c = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 compare("R1_reset");
    // R5: reserved codes ignored
    cyc(1, 2'b00, 16'h1111, 4'h1, 0, 0, "R5_code00");
    cyc(1, 2'b11, 16'h2222, 4'h2, 0, 0, "R5_code11");
    // R2: ordered storage
    cyc(1, 2'b10, 16'h0100, 4'h3, 0, 0, "R2_first");
    cyc(1, 2'b10, 16'h0208, 4'h5, 0, 0, "R2_second");
    cyc(1, 2'b10, 16'h0310, 4'h6, 0, 0, "R2_third");
    cyc(1, 2'b10, 16'h0418, 4'h7, 0, 0, "R2_fourth");
    // R3: drop on full, overflow sticky
    cyc(1, 2'b10, 16'hDEAD, 4'h9, 0, 0, "R3_drop");
    cyc(0, 2'b00, 16'h0, 4'h0, 0, 0, "R3_sticky");
    // R10: full push with pop
    cyc(1, 2'b10, 16'h0520, 4'hA, 1, 0, "R10_full_swap");
    // R7: overflow clear and new drop in same cycle -> set wins
    cyc(1, 2'b10, 16'hBEEF, 4'hB, 0, 3'b010, "R7_set_wins_ovf");
    cyc(0, 2'b00, 16'h0, 4'h0, 0, 3'b010, "R7_clear_ovf");
    // R4: drain and pop on empty
    for (int i = 0; i < D; i++) cyc(0, 2'b00, 16'h0, 4'h0, 1, 0, "R4_pop");
    cyc(0, 2'b00, 16'h0, 4'h0, 1, 0, "R4_pop_empty");
    // R10: empty push with pop
    cyc(1, 2'b10, 16'h0777, 4'hC, 1, 0, "R10_empty_pushpop");
    cyc(0, 2'b00, 16'h0, 4'h0, 1, 0, "R4_pop_one");
    // R6 / R8
    @(negedge clk); irq_en = 1; drs_sig_en = 1; drs_sig_sel = 0;
    cyc(1, 2'b01, 16'h0900, 4'h1, 0, 0, "R6_dev_ready");
    cyc(0, 2'b00, 16'h0, 4'h0, 0, 0, "R8_dev_irq");
    // R7: clear received with new device-ready -> set wins
    cyc(1, 2'b01, 16'h0900, 4'h1, 0, 3'b001, "R7_set_wins_rec");
    cyc(0, 2'b00, 16'h0, 4'h0, 0, 3'b101, "R7_clear_rec_pres");
    // R9: device-ready converted into a queue entry
    @(negedge clk); drs_sig_sel = 1;
    cyc(1, 2'b01, 16'h0900, 4'h2, 0, 0, "R9_self_entry");
    cyc(0, 2'b00, 16'h0, 4'h0, 0, 0, "R8_queue_irq");
    @(negedge clk); irq_en = 0;
    #1 compare("R8_irq_off");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      bit v = ($urandom % 4) != 0;
      logic [1:0] t = ($urandom % 8 < 5) ? 2'b10 : 2'($urandom);
      bit p = ($urandom % 5) < 2;
      logic [2:0] c = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      if (k % 200 == 0) begin
        @(negedge clk);
        irq_en = 1'($urandom); drs_sig_en = 1'($urandom); drs_sig_sel = 1'($urandom);
      end
      cyc(v, t, 16'($urandom), 4'($urandom), p, c, "RND");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule